// File: doc/BRIEF.md
# Byte-Segmented Watchdog Counter with Self-Test

This block is a 32-bit watchdog timer whose count is held in four cascaded 8-bit stages. The lowest stage advances on every clock. Each higher stage advances only when every stage below it reads all ones, so the four stages together behave as one binary counter. When the full count equals a programmable time-out value, the block emits a one-cycle watchdog reset pulse and restarts from zero. A refresh input restarts the count at any time and cancels a time-out that would otherwise fire.

For production test, a byte test mode checks one stage at a time. When the mode is entered, or when the selected stage changes, the stage just below the selected one is preloaded with all ones. The other stages, except the top one, are also preloaded with all ones. From then on the lower neighbour runs freely on every clock, the selected stage counts on each overflow of that neighbour, and all other stages hold. A time-out is then raised when the selected stage alone equals its own byte of the time-out value. This exercises both the selected stage and the carry link that feeds it, with short test times.

Top module: `bytewise_wdog`

## Requirements
- R1: After reset, countVal reads 0 and wdogRst is low.
- R2: Outside test mode the count rises by exactly 1 per clock. Byte k of countVal is countVal[8k+7:8k]. Byte k steps only on a clock where all bytes below k read 0xFF.
- R3: Outside test mode, a clock edge that sees countVal equal to timeoutVal drives wdogRst high for the next cycle and returns countVal to 0 at the same edge. wdogRst then falls unless a new match occurs.
- R4: A clock edge with refresh high sets countVal to 0 and leaves wdogRst low, even when a time-out match is present at that edge.
- R5: On the edge where testEn is first seen high, and on any edge where testEn is high and byteSel differs from its value at the previous edge, the following loads happen:
  - every byte other than the selected one and the top byte (byte 3) is loaded with 0xFF;
  - the selected byte keeps its value;
  - the top byte keeps its value unless it is the selected byte, in which case it also keeps its value.
- R6: During test counting with byteSel = N > 0, byte N-1 steps on every clock and byte N steps on clocks where byte N-1 reads 0xFF. All other bytes hold their value.
- R7: During test counting with byteSel = 0, byte 0 steps on every clock and all other bytes hold.
- R8: In test mode, only byte N of countVal is compared with byte N of timeoutVal. A match pulses wdogRst for one cycle and clears all four bytes to 0. Counting then continues under the same test rules.
- R9: byteSel is 2 bits wide, and value N selects byte N. testEn and byteSel take effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refresh | input | 1 | Restart the count and cancel a pending time-out |
| testEn | input | 1 | Byte test mode enable |
| byteSel | input | 2 | Index of the byte stage under test |
| timeoutVal | input | 32 | Time-out value |
| wdogRst | output | 1 | One-cycle watchdog reset pulse |
| countVal | output | 32 | Current count, byte k in bits 8k+7:8k |

## Verification
Each stage register is visible on countVal, so a stage that increments on the wrong carry, misses a preload, or fails to hold shows up as a wrong byte on the very next clock. Because of this, the checks sample the count right after the entry edge and right after the first carry into the tested stage. A wrong comparison, such as comparing the full word in test mode or the wrong byte, shows up as a wdogRst pulse on the wrong cycle. For that reason, the pulse is checked both one cycle before and exactly on the expected cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // width of one counter stage and number of stages
  localparam int STAGE_W = 8;
  localparam int STAGES  = 4;
  localparam int CNT_W   = STAGE_W * STAGES;
  localparam int SEL_W   = $clog2(STAGES);
  localparam int TOP_IDX = STAGES - 1;

  // strobes from the control block to the stage datapath
  typedef struct packed {
    logic              clearAll;   // return every stage to zero
    logic [STAGES-1:0] forceOnes;  // preload stage with all ones
    logic [STAGES-1:0] freeze;     // stage may not step
    logic [STAGES-1:0] freeRun;    // stage ignores the carry from below
  } stageCtl_t;
endpackage

// File: rtl/wdt_stage.sv
module wdt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         forceOnes,
  input  logic         freeze,
  input  logic         carryIn,
  output logic [W-1:0] value,
  output logic         carryOut
);
  logic [W-1:0] valueQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              valueQ <= '0;
    else if (clear)         valueQ <= '0;
    else if (forceOnes)     valueQ <= '1;
    else if (!freeze && carryIn) valueQ <= valueQ + W'(1);
  end

  assign value    = valueQ;
  assign carryOut = carryIn && (valueQ == {W{1'b1}});
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  stageCtl_t        ctl,
  output logic [CNT_W-1:0] countVal
);
  logic [STAGES:0]   carry;
  logic [STAGES-1:0] stageIn;

  assign carry[0] = 1'b1;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    assign stageIn[i] = ctl.freeRun[i] ? 1'b1 : carry[i];

    wdt_stage #(.W(STAGE_W)) i_stage (
      .clk      (clk),
      .rstN     (rstN),
      .clear    (ctl.clearAll),
      .forceOnes(ctl.forceOnes[i]),
      .freeze   (ctl.freeze[i]),
      .carryIn  (stageIn[i]),
      .value    (countVal[i*STAGE_W +: STAGE_W]),
      .carryOut (carry[i+1])
    );
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             refresh,
  input  logic             testEn,
  input  logic [SEL_W-1:0] byteSel,
  input  logic [CNT_W-1:0] timeoutVal,
  input  logic [CNT_W-1:0] countVal,
  output stageCtl_t        ctl,
  output logic             wdogRst,
  output logic             testModeQ,
  output logic [SEL_W-1:0] selQ,
  output logic             matchHit
);
  logic [STAGES-1:0] byteEq;
  logic              entryEdge;

  for (genvar i = 0; i < STAGES; i++) begin : g_cmp
    assign byteEq[i] = countVal[i*STAGE_W +: STAGE_W] == timeoutVal[i*STAGE_W +: STAGE_W];
  end

  assign matchHit  = testModeQ ? byteEq[selQ] : &byteEq;
  assign entryEdge = testEn && (!testModeQ || (byteSel != selQ));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      testModeQ <= 1'b0;
      selQ      <= '0;
      wdogRst   <= 1'b0;
    end else begin
      testModeQ <= testEn;
      selQ      <= byteSel;
      wdogRst   <= matchHit && !refresh;
    end
  end

  always_comb begin
    ctl.clearAll  = refresh || matchHit;
    ctl.forceOnes = '0;
    ctl.freeze    = '0;
    ctl.freeRun   = '0;
    if (entryEdge) begin
      ctl.freeze = '1;
      for (int i = 0; i < STAGES; i++) begin
        if ((i != int'(byteSel)) && (i != TOP_IDX)) ctl.forceOnes[i] = 1'b1;
      end
    end else if (testModeQ) begin
      for (int i = 0; i < STAGES; i++) begin
        ctl.freeze[i] = !((i == int'(selQ)) || (i + 1 == int'(selQ)));
      end
      if (selQ != '0) ctl.freeRun[selQ - SEL_W'(1)] = 1'b1;
    end
  end
endmodule

// File: rtl/bytewise_wdog.sv
module bytewise_wdog (
  input  logic        clk,
  input  logic        rstN,
  input  logic        refresh,
  input  logic        testEn,
  input  logic [1:0]  byteSel,
  input  logic [31:0] timeoutVal,
  output logic        wdogRst,
  output logic [31:0] countVal
);
  import wdt_pkg::*;

  stageCtl_t        ctl;
  logic             testModeQ;
  logic [SEL_W-1:0] selQ;
  logic             matchHit;

  wdt_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .refresh   (refresh),
    .testEn    (testEn),
    .byteSel   (byteSel),
    .timeoutVal(timeoutVal),
    .countVal  (countVal),
    .ctl       (ctl),
    .wdogRst   (wdogRst),
    .testModeQ (testModeQ),
    .selQ      (selQ),
    .matchHit  (matchHit)
  );

  wdt_datapath i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .countVal(countVal)
  );
endmodule

// File: rtl/bytewise_wdog_chk.sv
module bytewise_wdog_chk (
  input logic        clk,
  input logic        rstN,
  input logic        refresh,
  input logic        testEn,
  input logic [1:0]  byteSel,
  input logic [31:0] timeoutVal,
  input logic        wdogRst,
  input logic [31:0] countVal,
  input logic        testModeQ,
  input logic [1:0]  selQ,
  input logic        matchHit
);
  // R4
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    refresh |=> (countVal == 32'd0) && !wdogRst);

  // R3 R8
  pulse_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdogRst |-> (countVal == 32'd0));

  // R2
  normal_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!testModeQ && !testEn && !refresh && !matchHit) |=> (countVal == $past(countVal) + 32'd1));

  // R3
  normal_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!testModeQ && !refresh && (countVal == timeoutVal)) |=> wdogRst);

  // R6
  top_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testModeQ && testEn && (byteSel == selQ) && (selQ != 2'd3) && !refresh && !matchHit)
      |=> (countVal[31:24] == $past(countVal[31:24])));

  // R5
  lower_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (testEn && !testModeQ && !refresh && !matchHit && (byteSel != 2'd0))
      |=> (countVal[(int'($past(byteSel)) - 1) * 8 +: 8] == 8'hFF));
endmodule

bind bytewise_wdog bytewise_wdog_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refresh   (refresh),
  .testEn    (testEn),
  .byteSel   (byteSel),
  .timeoutVal(timeoutVal),
  .wdogRst   (wdogRst),
  .countVal  (countVal),
  .testModeQ (testModeQ),
  .selQ      (selQ),
  .matchHit  (matchHit)
);

// File: tb/test_bytewise_wdog.sv
module test_bytewise_wdog;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refresh = 1'b0;
  logic        testEn = 1'b0;
  logic [1:0]  byteSel = 2'd0;
  logic [31:0] timeoutVal = 32'hFFFF_FFFF;
  logic        wdogRst;
  logic [31:0] countVal;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bytewise_wdog i_bytewise_wdog (
    .clk(clk), .rstN(rstN), .refresh(refresh), .testEn(testEn),
    .byteSel(byteSel), .timeoutVal(timeoutVal),
    .wdogRst(wdogRst), .countVal(countVal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // advance n rising edges, return at the following falling edge
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doRefresh();
    refresh = 1'b1;
    testEn  = 1'b0;
    step(1);
    refresh = 1'b0;
  endtask

  task automatic tResetAndCount();
    check("R1 count after reset", countVal, 32'd0);
    check("R1 wdogRst after reset", {31'd0, wdogRst}, 32'd0);
    step(300);
    check("R2 binary count with carry into byte 1", countVal, 32'd300);
  endtask

  task automatic tTimeout();
    timeoutVal = 32'd20;
    doRefresh();
    check("R4 refresh clears", countVal, 32'd0);
    step(20);
    check("R3 count reaches timeout", countVal, 32'd20);
    check("R3 no pulse before match edge", {31'd0, wdogRst}, 32'd0);
    step(1);
    check("R3 pulse on match", {31'd0, wdogRst}, 32'd1);
    check("R3 count cleared on match", countVal, 32'd0);
    step(1);
    check("R3 pulse is single cycle", {31'd0, wdogRst}, 32'd0);
    check("R3 count restarts", countVal, 32'd1);
  endtask

  task automatic tRefreshWins();
    timeoutVal = 32'd20;
    doRefresh();
    step(20);
    refresh = 1'b1;
    step(1);
    refresh = 1'b0;
    check("R4 refresh suppresses pulse", {31'd0, wdogRst}, 32'd0);
    check("R4 refresh clears at match", countVal, 32'd0);
  endtask

  task automatic tByte1();
    timeoutVal = 32'hAABB_03CC;
    doRefresh();
    testEn = 1'b1; byteSel = 2'd1;
    step(1);
    check("R5 R9 entry preload sel 1", countVal, 32'h00FF_00FF);
    step(1);
    check("R6 first carry into byte 1", countVal, 32'h00FF_0100);
    step(256);
    check("R6 byte 1 steps after byte 0 wraps", countVal, 32'h00FF_0200);
    step(256);
    check("R8 byte 1 equals timeout byte", countVal, 32'h00FF_0300);
    check("R8 no pulse before match edge", {31'd0, wdogRst}, 32'd0);
    step(1);
    check("R8 byte match pulses", {31'd0, wdogRst}, 32'd1);
    check("R8 byte match clears all", countVal, 32'd0);
    doRefresh();
  endtask

  task automatic tByte0();
    timeoutVal = 32'h1122_3305;
    doRefresh();
    testEn = 1'b1; byteSel = 2'd0;
    step(1);
    check("R5 entry preload sel 0", countVal, 32'h00FF_FF00);
    step(5);
    check("R7 byte 0 steps alone", countVal, 32'h00FF_FF05);
    step(1);
    check("R8 byte 0 match pulses", {31'd0, wdogRst}, 32'd1);
    step(1);
    check("R7 byte 0 runs after clear", countVal, 32'd1);
    doRefresh();
  endtask

  task automatic tByte3();
    timeoutVal = 32'h0144_5566;
    doRefresh();
    testEn = 1'b1; byteSel = 2'd3;
    step(1);
    check("R5 entry preload sel 3", countVal, 32'h00FF_FFFF);
    step(1);
    check("R6 top byte steps from forced byte 2", countVal, 32'h0100_FFFF);
    step(1);
    check("R8 top byte match pulses", {31'd0, wdogRst}, 32'd1);
    doRefresh();
  endtask

  task automatic tSelChange();
    timeoutVal = 32'hAABB_03CC;
    doRefresh();
    testEn = 1'b1; byteSel = 2'd1;
    step(2);
    byteSel = 2'd2;
    step(1);
    check("R5 select change reloads", countVal, 32'h00FF_FFFF);
    step(1);
    check("R6 sel 2 runs bytes 1 and 2 only", countVal, 32'h0000_00FF);
    doRefresh();
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
          total++;
          bad++;
          $display("FAIL watchdog expired");
          $display("  test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tResetAndCount();
    tTimeout();
    tRefreshWins();
    tByte1();
    tByte0();
    tByte3();
    tSelChange();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule